// File: doc/BRIEF.md
# Unlock Sequence Command Decoder

This block sits on a host write bus in front of a one-time-programmable memory. It observes every accepted write, each an address and a data byte, and recognises command sequences of three writes. The first two form a fixed unlock key and the third carries a command code. A decoded command can steer the read path to the memory array, the identifier codes or the status register. It can also fire a one-cycle request that starts a program operation, or a one-cycle request that clears the status flags.

A program controller drives `prog_busy` while an operation runs. During that time reads are steered to status and only the read-status command has an effect. A low-supply indication stops the decoder from taking writes, clears any partly entered sequence and returns the read path to the array. The host write port uses valid/ready. A write is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while `supply_low` is high. A host holding `wr_valid` then waits, and no write is lost or taken twice.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: During and after reset, `rd_sel` is 0 (array) while `prog_busy` is low, and `prog_start` and `clr_status` are low, with no write needed.
- R2: The unlock key is data AAh at an address whose bits 14..0 equal 5555h, then data 55h at bits 14..0 equal to 2AAAh. Address bits above bit 14 are ignored.
- R3: A key followed by a third write at address bits 14..0 = 5555h with code F0h, 90h or 70h sets `rd_sel` to 0 (array), 1 (identifier) or 2 (status). The new value shows from the cycle after the clock edge that took the third write.
- R4: Code A0h sets `rd_sel` to 2 and raises `prog_start` for exactly one cycle, in the cycle after the edge that took the third write.
- R5: Code 50h raises `clr_status` for exactly one cycle, in the cycle after the edge that took the third write, and leaves `rd_sel` unchanged.
- R6: The selected read mode holds through idle cycles and through incomplete sequences until another complete, valid sequence is decoded.
- R7: A taken write that does not match the step it is expected for returns the tracker to its start without changing `rd_sel`. The key must then be entered again from its first write.
- R8: A third write with an unknown code, or at an address whose bits 14..0 are not 5555h, is discarded and the tracker returns to its start.
- R9: While `prog_busy` is high, `rd_sel` reads 2 and codes F0h, 90h, A0h and 50h have no effect. After `prog_busy` falls, `rd_sel` stays 2 until a new command.
- R10: While `supply_low` is high, `wr_ready` is low and no write is taken. On the next cycle `rd_sel` is 0 (when not busy). A partly entered sequence is discarded.
- R11: A write is taken only on a cycle with `wr_valid` and `wr_ready` both high. A write presented with `wr_valid` low leaves the tracker where it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Host write present |
| wr_ready | output | 1 | Decoder takes writes (low while supply is low) |
| wr_addr | input | ADDR_W (20) | Write address |
| wr_data | input | DATA_W (8) | Write data |
| prog_busy | input | 1 | Program operation in progress |
| supply_low | input | 1 | Low-supply write inhibit |
| rd_sel | output | 2 | Read path: 0 array, 1 identifier, 2 status |
| prog_start | output | 1 | One-cycle request to start programming |
| clr_status | output | 1 | One-cycle request to clear status flags |

## Verification
Each result of a command is due one cycle after the clock edge that takes the third write. This covers the new `rd_sel` value and the one-cycle `prog_start` or `clr_status` pulse. The pulse must be gone one cycle later. `rd_sel` follows `prog_busy` within the same cycle, and `wr_ready` follows `supply_low` within the same cycle. The driver holds each stimulus across a full cycle and queues the expected outputs for that cycle. The monitor compares them at the falling edge, after the register update and before the driver moves on. Every queued entry is therefore checked at the cycle where the requirements place the result.

// File: rtl/ucd_pkg.sv
package ucd_pkg;
  localparam int KEY_W = 15;
  localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] KEY_DATA_A = 8'hAA;
  localparam logic [7:0] KEY_DATA_B = 8'h55;

  localparam logic [7:0] CODE_ARRAY  = 8'hF0;
  localparam logic [7:0] CODE_IDENT  = 8'h90;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_STATUS = 8'h70;
  localparam logic [7:0] CODE_CLEAR  = 8'h50;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } rd_path_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_READ_ARRAY,
    CMD_READ_IDENT,
    CMD_PROGRAM,
    CMD_READ_STATUS,
    CMD_CLEAR
  } cmd_e;

  typedef enum logic [1:0] {
    STEP_IDLE,
    STEP_HAVE_A,
    STEP_HAVE_B
  } step_e;

  function automatic cmd_e decode_code(input logic [7:0] code);
    case (code)
      CODE_ARRAY:  return CMD_READ_ARRAY;
      CODE_IDENT:  return CMD_READ_IDENT;
      CODE_PROG:   return CMD_PROGRAM;
      CODE_STATUS: return CMD_READ_STATUS;
      CODE_CLEAR:  return CMD_CLEAR;
      default:     return CMD_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ucd_match.sv
module ucd_match
  import ucd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              hit_a,
  output logic              hit_b,
  output logic              hit_cmd_addr,
  output cmd_e              cmd
);
  logic [KEY_W-1:0] key_bits;
  logic [7:0]       low_byte;
  logic             upper_clear;

  assign key_bits = addr[KEY_W-1:0];
  assign low_byte = data[7:0];

  generate
    if (DATA_W > 8) begin : g_wide
      assign upper_clear = (data[DATA_W-1:8] == '0);
    end else begin : g_narrow
      assign upper_clear = 1'b1;
    end
  endgenerate

  always_comb begin
    hit_a        = upper_clear && (key_bits == KEY_ADDR_A) && (low_byte == KEY_DATA_A);
    hit_b        = upper_clear && (key_bits == KEY_ADDR_B) && (low_byte == KEY_DATA_B);
    hit_cmd_addr = (key_bits == KEY_ADDR_A);
    cmd          = upper_clear ? decode_code(low_byte) : CMD_NONE;
  end
endmodule

// File: rtl/ucd_tracker.sv
module ucd_tracker
  import ucd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic inhibit,
  input  logic hit_a,
  input  logic hit_b,
  input  logic hit_cmd_addr,
  input  cmd_e cmd,
  output logic fire,
  output cmd_e fire_cmd
);
  step_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    if (inhibit) begin
      step_d = STEP_IDLE;
    end else if (take) begin
      case (step_q)
        STEP_IDLE:   step_d = hit_a ? STEP_HAVE_A : STEP_IDLE;
        STEP_HAVE_A: step_d = hit_b ? STEP_HAVE_B : STEP_IDLE;
        default:     step_d = STEP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= STEP_IDLE;
    else        step_q <= step_d;
  end

  assign fire     = take && !inhibit && (step_q == STEP_HAVE_B) &&
                    hit_cmd_addr && (cmd != CMD_NONE);
  assign fire_cmd = cmd;
endmodule

// File: rtl/ucd_dispatch.sv
module ucd_dispatch
  import ucd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  cmd_e       fire_cmd,
  input  logic       busy,
  input  logic       inhibit,
  output logic [1:0] rd_sel,
  output logic       prog_start,
  output logic       clr_status
);
  rd_path_e mode_q;
  logic     start_q;
  logic     clear_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= RD_ARRAY;
      start_q <= 1'b0;
      clear_q <= 1'b0;
    end else if (inhibit) begin
      mode_q  <= RD_ARRAY;
      start_q <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      clear_q <= 1'b0;
      if (fire) begin
        case (fire_cmd)
          CMD_READ_ARRAY:  if (!busy) mode_q <= RD_ARRAY;
          CMD_READ_IDENT:  if (!busy) mode_q <= RD_IDENT;
          CMD_PROGRAM: begin
            if (!busy) begin
              start_q <= 1'b1;
              mode_q  <= RD_STATUS;
            end
          end
          CMD_READ_STATUS: mode_q <= RD_STATUS;
          CMD_CLEAR:       if (!busy) clear_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign rd_sel     = busy ? RD_STATUS : mode_q;
  assign prog_start = start_q;
  assign clr_status = clear_q;
endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
  import ucd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_busy,
  input  logic              supply_low,
  output logic [1:0]        rd_sel,
  output logic              prog_start,
  output logic              clr_status
);
  logic take;
  logic hit_a, hit_b, hit_cmd_addr;
  cmd_e cmd;
  logic fire;
  cmd_e fire_cmd;

  assign wr_ready = !supply_low;
  assign take     = wr_valid && wr_ready;

  ucd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .addr(wr_addr), .data(wr_data),
    .hit_a(hit_a), .hit_b(hit_b), .hit_cmd_addr(hit_cmd_addr), .cmd(cmd)
  );

  ucd_tracker u_track (
    .clk(clk), .rst_n(rst_n), .take(take), .inhibit(supply_low),
    .hit_a(hit_a), .hit_b(hit_b), .hit_cmd_addr(hit_cmd_addr), .cmd(cmd),
    .fire(fire), .fire_cmd(fire_cmd)
  );

  ucd_dispatch u_disp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_cmd(fire_cmd),
    .busy(prog_busy), .inhibit(supply_low),
    .rd_sel(rd_sel), .prog_start(prog_start), .clr_status(clr_status)
  );
endmodule

// File: rtl/ucd_checker.sv
module ucd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       prog_busy,
  input logic       supply_low,
  input logic [1:0] rd_sel,
  input logic       prog_start,
  input logic       clr_status
);
  // R4
  prog_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  // R5
  clear_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status |=> !clr_status);

  // R11
  no_write_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> (!prog_start && !clr_status));

  // R9
  busy_reads_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> (rd_sel == 2'd2));

  // R9
  busy_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |=> !prog_start);

  // R10
  inhibit_to_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> (prog_busy || rd_sel == 2'd0));

  // R6
  mode_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_valid && wr_ready) && !supply_low && !prog_busy) |=>
      (prog_busy || $stable(rd_sel)));
endmodule

bind unlock_cmd_decoder ucd_checker chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .prog_busy(prog_busy), .supply_low(supply_low), .rd_sel(rd_sel),
  .prog_start(prog_start), .clr_status(clr_status)
);

// File: tb/unlock_cmd_decoder_test.sv
module unlock_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_busy = 1'b0;
  logic        supply_low = 1'b0;
  logic [1:0]  rd_sel;
  logic        prog_start;
  logic        clr_status;

  always #4 clk = ~clk;

  unlock_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .prog_busy(prog_busy),
    .supply_low(supply_low), .rd_sel(rd_sel), .prog_start(prog_start),
    .clr_status(clr_status)
  );

  typedef struct {
    logic [1:0] sel;
    logic       ps;
    logic       cs;
    logic       rdy;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;
  logic [1:0] cur = 2'd0;

  function automatic logic [1:0] view();
    return prog_busy ? 2'd2 : cur;
  endfunction

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (rd_sel !== e.sel || prog_start !== e.ps || clr_status !== e.cs ||
          wr_ready !== e.rdy) begin
        n_fail++;
        $display("FAIL %s: got sel=%0d ps=%0b cs=%0b rdy=%0b exp sel=%0d ps=%0b cs=%0b rdy=%0b",
                 e.tag, rd_sel, prog_start, clr_status, wr_ready,
                 e.sel, e.ps, e.cs, e.rdy);
      end
    end
  end

  task automatic step(input logic v, input logic [19:0] a, input logic [7:0] d,
                      input logic [1:0] esel, input logic eps, input logic ecs,
                      input string tag);
    exp_t e;
    wr_valid = v;
    wr_addr  = a;
    wr_data  = d;
    @(posedge clk);
    e.sel = esel; e.ps = eps; e.cs = ecs; e.rdy = !supply_low; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic seq(input logic [19:0] a3, input logic [7:0] code,
                     input logic [1:0] esel, input logic eps, input logic ecs,
                     input string tag);
    step(1'b1, 20'h05555, 8'hAA, view(), 1'b0, 1'b0, tag);
    step(1'b1, 20'h02AAA, 8'h55, view(), 1'b0, 1'b0, tag);
    step(1'b1, a3, code, esel, eps, ecs, tag);
    step(1'b0, 20'h0, 8'h00, esel, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #1;
    step(1'b0, 20'h0, 8'h00, 2'd0, 1'b0, 1'b0, "R1 in reset");
    step(1'b1, 20'h05555, 8'hAA, 2'd0, 1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    step(1'b0, 20'h0, 8'h00, 2'd0, 1'b0, 1'b0, "R1 after reset");
    step(1'b0, 20'h0, 8'h00, 2'd0, 1'b0, 1'b0, "R1 after reset");

    // R3 each read selection
    seq(20'h05555, 8'h90, 2'd1, 1'b0, 1'b0, "R3 ident"); cur = 2'd1;
    seq(20'h05555, 8'h70, 2'd2, 1'b0, 1'b0, "R3 status"); cur = 2'd2;
    seq(20'h05555, 8'hF0, 2'd0, 1'b0, 1'b0, "R3 array"); cur = 2'd0;

    // R2 upper address bits ignored
    step(1'b1, 20'hF5555, 8'hAA, 2'd0, 1'b0, 1'b0, "R2 key a");
    step(1'b1, 20'h8AAAA, 8'h55, 2'd0, 1'b0, 1'b0, "R2 key b");
    step(1'b1, 20'h7D555, 8'h90, 2'd1, 1'b0, 1'b0, "R2 cmd"); cur = 2'd1;

    // R6 idle and partial sequences keep the mode
    for (int i = 0; i < 3; i++) step(1'b0, 20'h05555, 8'hF0, 2'd1, 1'b0, 1'b0, "R6 idle");
    step(1'b1, 20'h05555, 8'hAA, 2'd1, 1'b0, 1'b0, "R6 partial");
    step(1'b1, 20'h02AAA, 8'h55, 2'd1, 1'b0, 1'b0, "R6 partial");
    step(1'b1, 20'h01234, 8'h00, 2'd1, 1'b0, 1'b0, "R7 stray third");
    step(1'b1, 20'h05555, 8'hF0, 2'd1, 1'b0, 1'b0, "R7 lone cmd");

    // R7 mismatched second write
    step(1'b1, 20'h05555, 8'hAA, 2'd1, 1'b0, 1'b0, "R7 key a");
    step(1'b1, 20'h02AAA, 8'h00, 2'd1, 1'b0, 1'b0, "R7 bad key b");
    step(1'b1, 20'h02AAA, 8'h55, 2'd1, 1'b0, 1'b0, "R7 late key b");
    step(1'b1, 20'h05555, 8'hF0, 2'd1, 1'b0, 1'b0, "R7 no restart");

    // R8 unknown code, wrong command address
    seq(20'h05555, 8'h12, 2'd1, 1'b0, 1'b0, "R8 unknown code");
    seq(20'h01555, 8'hF0, 2'd1, 1'b0, 1'b0, "R8 wrong addr");
    step(1'b1, 20'h05555, 8'hF0, 2'd1, 1'b0, 1'b0, "R8 tracker idle");

    // R5 clear status
    seq(20'h05555, 8'h50, 2'd1, 1'b0, 1'b1, "R5 clear");

    // R4 program
    seq(20'h05555, 8'hA0, 2'd2, 1'b1, 1'b0, "R4 program"); cur = 2'd2;

    // R9 busy lockout
    prog_busy = 1'b1;
    seq(20'h05555, 8'hF0, 2'd2, 1'b0, 1'b0, "R9 busy array");
    seq(20'h05555, 8'h90, 2'd2, 1'b0, 1'b0, "R9 busy ident");
    seq(20'h05555, 8'hA0, 2'd2, 1'b0, 1'b0, "R9 busy program");
    seq(20'h05555, 8'h50, 2'd2, 1'b0, 1'b0, "R9 busy clear");
    seq(20'h05555, 8'h70, 2'd2, 1'b0, 1'b0, "R9 busy status");
    prog_busy = 1'b0;
    step(1'b0, 20'h0, 8'h00, 2'd2, 1'b0, 1'b0, "R9 after busy");
    seq(20'h05555, 8'h90, 2'd1, 1'b0, 1'b0, "R9 unlocked"); cur = 2'd1;

    // R11 write with valid low not taken
    step(1'b1, 20'h05555, 8'hAA, 2'd1, 1'b0, 1'b0, "R11 key a");
    step(1'b1, 20'h02AAA, 8'h55, 2'd1, 1'b0, 1'b0, "R11 key b");
    step(1'b0, 20'h01234, 8'h00, 2'd1, 1'b0, 1'b0, "R11 valid low");
    step(1'b1, 20'h05555, 8'hF0, 2'd0, 1'b0, 1'b0, "R11 cmd"); cur = 2'd0;

    // R10 supply inhibit
    seq(20'h05555, 8'h90, 2'd1, 1'b0, 1'b0, "R10 setup"); cur = 2'd1;
    step(1'b1, 20'h05555, 8'hAA, 2'd1, 1'b0, 1'b0, "R10 key a");
    step(1'b1, 20'h02AAA, 8'h55, 2'd1, 1'b0, 1'b0, "R10 key b");
    supply_low = 1'b1; cur = 2'd0;
    step(1'b1, 20'h05555, 8'h70, 2'd0, 1'b0, 1'b0, "R10 inhibit");
    seq(20'h05555, 8'hA0, 2'd0, 1'b0, 1'b0, "R10 writes dropped");
    supply_low = 1'b0;
    step(1'b1, 20'h05555, 8'h90, 2'd0, 1'b0, 1'b0, "R10 tracker cleared");
    step(1'b0, 20'h0, 8'h00, 2'd0, 1'b0, 1'b0, "R10 recover");

    step(1'b0, 20'h0, 8'h00, 2'd0, 1'b0, 1'b0, "R1 tail");
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule